// File: doc/BRIEF.md
# Ready-Paced Tone Stream Source

This block produces a complex tone as a packetized stream of samples for a radio transmit port. A 32-bit phase accumulator advances by a host-supplied step once per emitted sample. The top ten bits of the phase index a sine table built from a 257-entry quarter wave. Each sample packs a cosine (I) and sine (Q) pair into one 32-bit word. The downstream consumer sets the pace: a sample is presented in exactly the cycles in which it raises `dn_ready`, whatever its duty cycle.

A transmit enable opens and closes a burst. While a burst runs, every 256th sample carries a packet-end flag. When the enable is seen low on a handshake, that sample closes the burst and carries both the end-of-burst flag and the packet-end flag. The stream then stays silent until the enable is raised again. The next burst starts a fresh packet at phase zero.

Top module: `tone_stream_src`

## Requirements
- R1: While a burst is open, `tx_valid` equals `dn_ready` in every cycle. Outside a burst, `tx_valid` is 0.
- R2: `tx_data[31:16]` holds I = 32767·cos(2π·p/1024) and `tx_data[15:0]` holds Q = 32767·sin(2π·p/1024). Both are signed two's complement, each within 64 LSB. Here p is the phase bits [31:22] of the sample.
- R3: The first sample of a burst has phase 0. Each later sample's phase equals the previous sample's phase plus the `phase_step` value present on that previous handshake, modulo 2^32.
- R4: `tx_last` is 1 on the 256th, 512th, … valid sample of a burst.
- R5: A valid sample presented while `tx_en` is 0 carries `tx_eob` = 1 and `tx_last` = 1. A valid sample presented while `tx_en` is 1 carries `tx_eob` = 0.
- R6: After the end-of-burst sample, `tx_valid` stays 0 while `tx_en` is 0. The next burst restarts the packet count and the phase.
- R7: A burst opens on the clock edge at which `tx_en` is sampled 1 while idle. The first valid sample can appear in the following cycle.
- R8: During and right after reset, `tx_valid`, `tx_last` and `tx_eob` are 0.
- R9: `tx_last` and `tx_eob` are 0 in any cycle where `tx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; opens a burst when high, closes it when low |
| phase_step | input | 32 | Phase increment per sample, from a host register |
| dn_ready | input | 1 | Downstream request for a sample this cycle |
| tx_data | output | 32 | Packed sample: I in [31:16], Q in [15:0] |
| tx_valid | output | 1 | Sample present this cycle |
| tx_last | output | 1 | Packet end |
| tx_eob | output | 1 | End of burst |

## Verification
The bench drives bursts with ready on every cycle and with ready on one cycle in two, three and four. It uses burst lengths that put the end-of-burst sample just after, exactly on, and well before a 256-sample boundary.

A counter that is off by one would show up as a packet-end flag on the wrong sample, or as two flags. Losing the pending close would show up in a different way. To catch it, the enable is dropped while ready is low and the close must wait for the next request. The enable is also dropped and raised again before any request: a design that latched the drop would then end the burst by mistake.

After a burst closes, the bench keeps ready high with the enable low, so a source that kept running would be seen. On restart it checks that the first sample is back at phase zero (I at full scale, Q near 0) and that a packet-end flag does not come early.

// File: rtl/tone_pkg.sv
package tone_pkg;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} burst_state_e;

  // Rational sine approximation on a quarter wave of qn steps:
  // sin(pi/2 * k/qn) ~= 4k(2qn-k) / (5qn^2 - k(2qn-k))
  function automatic logic [15:0] quarter_sine(input int k, input int qn, input int amp);
    longint prod;
    longint num;
    longint den;
    prod = longint'(k) * longint'(2 * qn - k);
    num  = longint'(amp) * 4 * prod;
    den  = 5 * longint'(qn) * longint'(qn) - prod;
    return 16'((num + den / 2) / den);
  endfunction

  function automatic logic [31:0] pack_iq(input logic [15:0] i_val, input logic [15:0] q_val);
    return {i_val, q_val};
  endfunction

endpackage

// File: rtl/tone_phase_acc.sv
module tone_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               clr,
  input  logic [PHASE_W-1:0] step,
  output logic [PHASE_W-1:0] phase
);

  always_ff @(posedge clk) begin
    if (!rst_n)          phase <= '0;
    else if (adv && clr) phase <= '0;
    else if (adv)        phase <= phase + step;
  end

  // R3: phase moves by the step on a handshake and holds otherwise
  a_r3_phase_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> phase == $past(phase) + $past(step));
  a_r3_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(phase));
  a_r6_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && clr) |=> phase == '0);

endmodule

// File: rtl/tone_lut.sv
module tone_lut #(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 10,
  parameter int AMP     = 32767
) (
  input  logic [PHASE_W-1:0] phase,
  output logic [15:0]        i_out,
  output logic [15:0]        q_out
);
  import tone_pkg::*;

  localparam int QBITS = IDX_W - 2;
  localparam int QN    = 1 << QBITS;

  logic [15:0] rom [0:QN];
  logic [15:0] chan [0:1];

  for (genvar r = 0; r <= QN; r++) begin : g_rom
    assign rom[r] = quarter_sine(r, QN, AMP);
  end

  // channel 0 = sine, channel 1 = cosine (index advanced by a quarter turn)
  for (genvar c = 0; c < 2; c++) begin : g_chan
    logic [IDX_W-1:0] idx;
    logic [1:0]       quad;
    logic [QBITS:0]   k;
    logic [15:0]      mag;
    assign idx  = phase[PHASE_W-1 -: IDX_W] + IDX_W'(c * QN);
    assign quad = idx[IDX_W-1 -: 2];
    always_comb begin
      k = {1'b0, idx[QBITS-1:0]};
      if (quad[0]) k = (QBITS+1)'(QN) - k;
      mag = rom[k];
      chan[c] = quad[1] ? 16'(-mag) : mag;
    end
  end

  assign q_out = chan[0];
  assign i_out = chan[1];

  // R2: the table output stays within full scale
  always_comb begin
    a_r2_in_range: assert ($signed(i_out) >= -AMP && $signed(q_out) >= -AMP);
  end

endmodule

// File: rtl/tone_framer.sv
module tone_framer #(
  parameter int PKT_LEN = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic dn_ready,
  output logic fire,
  output logic close,
  output logic pkt_end
);
  import tone_pkg::*;

  localparam int CW = $clog2(PKT_LEN);

  burst_state_e   state;
  logic [CW-1:0]  cnt;
  logic           running;
  logic           at_boundary;

  assign running     = (state == ST_RUN);
  assign fire        = running && dn_ready;
  assign close       = fire && !tx_en;
  assign at_boundary = (cnt == CW'(PKT_LEN - 1));
  assign pkt_end     = fire && (at_boundary || !tx_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (!running) begin
      if (tx_en) state <= ST_RUN;
    end else if (close) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (fire) begin
      cnt <= at_boundary ? '0 : cnt + 1'b1;
    end
  end

  // independent sample counter for the packet-spacing check
  logic [CW:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n)                 gap <= '0;
    else if (fire && pkt_end)   gap <= '0;
    else if (fire)              gap <= gap + 1'b1;
  end

  a_r1_valid_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> dn_ready);
  a_r4_packet_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && gap == (CW+1)'(PKT_LEN - 1)) |-> pkt_end);
  a_r5_eob_is_last: assert property (@(posedge clk) disable iff (!rst_n)
    close |-> pkt_end);
  a_r6_silent_after_eob: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> !fire);
  a_r7_no_early_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !tx_en) |=> !fire);
  a_r9_flags_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |-> (!pkt_end && !close));

endmodule

// File: rtl/tone_stream_src.sv
module tone_stream_src #(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 10,
  parameter int AMP     = 32767,
  parameter int PKT_LEN = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic [PHASE_W-1:0] phase_step,
  input  logic               dn_ready,
  output logic [31:0]        tx_data,
  output logic               tx_valid,
  output logic               tx_last,
  output logic               tx_eob
);
  import tone_pkg::*;

  logic               fire;
  logic               close;
  logic               pkt_end;
  logic [PHASE_W-1:0] phase;
  logic [15:0]        i_val;
  logic [15:0]        q_val;

  tone_framer #(.PKT_LEN(PKT_LEN)) u_framer (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .dn_ready(dn_ready),
    .fire(fire), .close(close), .pkt_end(pkt_end)
  );

  tone_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .adv(fire), .clr(close),
    .step(phase_step), .phase(phase)
  );

  tone_lut #(.PHASE_W(PHASE_W), .IDX_W(IDX_W), .AMP(AMP)) u_lut (
    .phase(phase), .i_out(i_val), .q_out(q_val)
  );

  assign tx_data  = pack_iq(i_val, q_val);
  assign tx_valid = fire;
  assign tx_last  = pkt_end;
  assign tx_eob   = close;

  // R8: nothing is presented in the first cycle after reset
  a_r8_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> !tx_valid);

endmodule

// File: tb/tone_stream_src_bench.sv
module tone_stream_src_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0;
  logic [31:0] phase_step = '0;
  logic        dn_ready = 1'b0;
  logic [31:0] tx_data;
  logic        tx_valid, tx_last, tx_eob;

  always #4 clk = ~clk;

  tone_stream_src u_tone_stream_src (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .phase_step(phase_step),
    .dn_ready(dn_ready), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_last(tx_last), .tx_eob(tx_eob)
  );

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  bit          m_run = 0;
  int          m_cnt = 0;
  logic [31:0] m_phase = '0;
  int          n_lasts = 0;
  int          n_samp = 0;

  // stimulus rows: step, ready period, samples with enable high, expected packet ends
  typedef struct packed { logic [31:0] step; int per; int nsamp; int exp_lasts; } row_t;
  localparam row_t ROWS [0:3] = '{
    '{32'h0100_0000, 1, 300, 2},
    '{32'h0040_0000, 4, 255, 1},
    '{32'hFFC0_0000, 3, 511, 2},
    '{32'h1234_5678, 2,  40, 1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic en, input logic rdy, input logic [31:0] stp);
    bit ev, el, ee;
    int ei, eq, ai, aq, p;
    @(negedge clk);
    tx_en = en; dn_ready = rdy; phase_step = stp;
    #1;
    ev = m_run && rdy;
    check(tx_valid == ev, "R1/R6/R7 valid", int'(tx_valid), int'(ev));
    if (ev) begin
      el = (m_cnt == 255) || !en;
      ee = !en;
      check(tx_last == el, "R4 last", int'(tx_last), int'(el));
      check(tx_eob == ee, "R5 eob", int'(tx_eob), int'(ee));
      p  = int'(m_phase[31:22]);
      ei = int'(32767.0 * $cos(6.283185307179586 * p / 1024.0));
      eq = int'(32767.0 * $sin(6.283185307179586 * p / 1024.0));
      ai = int'($signed(tx_data[31:16]));
      aq = int'($signed(tx_data[15:0]));
      check((ai - ei <= 64) && (ei - ai <= 64), "R2/R3 I", ai, ei);
      check((aq - eq <= 64) && (eq - aq <= 64), "R2/R3 Q", aq, eq);
      n_samp++;
      if (tx_last) n_lasts++;
      if (!en) begin m_run = 0; m_cnt = 0; m_phase = '0; end
      else begin m_cnt = (m_cnt == 255) ? 0 : m_cnt + 1; m_phase = m_phase + stp; end
    end else begin
      check(!tx_last && !tx_eob, "R9 flags", int'({tx_last, tx_eob}), 0);
      if (!m_run) m_run = en;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        done = 1;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    // R8: reset holds outputs quiet even with enable and ready high
    tx_en = 1'b1; dn_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!tx_valid && !tx_last && !tx_eob, "R8 reset", int'({tx_valid, tx_last, tx_eob}), 0);
    rst_n = 1'b1; tx_en = 1'b0;
    @(negedge clk); #1;
    check(!tx_valid, "R8 after reset", int'(tx_valid), 0);

    // table walk
    foreach (ROWS[r]) begin
      int c = 0;
      int guard = 0;
      n_lasts = 0; n_samp = 0;
      while (n_samp < ROWS[r].nsamp && guard < 20000) begin
        cyc(1'b1, (c % ROWS[r].per) == 0, ROWS[r].step);
        c++; guard++;
      end
      while (m_run && guard < 20000) begin
        cyc(1'b0, (c % ROWS[r].per) == 0, ROWS[r].step);
        c++; guard++;
      end
      check(n_lasts == ROWS[r].exp_lasts, "R4 packet ends per burst", n_lasts, ROWS[r].exp_lasts);
      check(n_samp == ROWS[r].nsamp + 1, "R5 burst length", n_samp, ROWS[r].nsamp + 1);
    end

    // R6: idle with ready high and enable low stays silent
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, 32'h0100_0000);

    // R5: enable dropped and raised again before any request does not close
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 32'h0200_0000);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 32'h0200_0000);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 32'h0200_0000);
    // R5: close waits for the next request
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 32'h0200_0000);
    n_lasts = 0;
    cyc(1'b0, 1'b1, 32'h0200_0000);
    check(n_lasts == 1, "R5 delayed close", n_lasts, 1);

    // R6: restart at phase zero with a fresh packet count
    cyc(1'b1, 1'b1, 32'h0040_0000);
    @(negedge clk);
    tx_en = 1'b1; dn_ready = 1'b1; #1;
    check(int'($signed(tx_data[31:16])) >= 32700, "R6 restart I", int'($signed(tx_data[31:16])), 32767);
    check(int'($signed(tx_data[15:0])) == 0, "R6 restart Q", int'($signed(tx_data[15:0])), 0);
    m_cnt = 1; m_phase = 32'h0040_0000;
    n_lasts = 0;
    for (int i = 0; i < 254; i++) cyc(1'b1, 1'b1, 32'h0040_0000);
    check(n_lasts == 0, "R4 no early packet end", n_lasts, 0);
    cyc(1'b1, 1'b1, 32'h0040_0000);
    check(n_lasts == 1, "R4 end at 256", n_lasts, 1);
    while (m_run) cyc(1'b0, 1'b1, 32'h0040_0000);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule